// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Access Controller

This synchronous block accepts single read and write requests from a host and turns each one into the strobe sequence that an asynchronous fast-page-mode DRAM expects. The flat host address is split into a row part and a column part. Both parts go out on one shared address bus: the row goes out first, under the row strobe (`ras_n`), and then the column, under the column strobe (`cas_n`). After an access the row is left open. A later request to the same row therefore needs only a new column strobe. A request to a different row first closes the page, waits out the row precharge and then opens the new row.

All DRAM timing is given as whole clock cycles through parameters. The integrator derives these counts from the clock period and the device speed grade. Writes are always early writes, so the controller and the memory never drive the data pins at the same time. An external refresh engine asks for the bus with `refresh_req`. The controller then closes the page and raises `refresh_ok` once precharge is complete. A row that is left open with no traffic is closed on its own before the longest allowed row-strobe low time runs out.

Top module: `fpm_page_ctrl`

## Requirements
- R1: The row field `req_addr[ROW_W+COL_W-1:COL_W]` is on `dram_addr` when `ras_n` falls. The column field `req_addr[COL_W-1:0]`, zero-extended to `dram_addr`, is on `dram_addr` when `cas_n` falls. Accesses reach the DRAM in the order the host handed them over.
- R2: The row address stays on the bus for at least RAH_CYC cycles after `ras_n` falls. `cas_n` falls no earlier than RAH_CYC+1 cycles after `ras_n` falls.
- R3: `cas_n` is low for exactly CAS_CYC cycles per access, and only while `ras_n` is low. `dram_addr` does not change while `cas_n` is low. Within a page, `cas_n` is high for at least CP_CYC cycles between two column strobes.
- R4: A request whose row equals the open row is served without `ras_n` going high.
- R5: A request to a different row closes the page and then opens the new row. Its column access follows without any further host action.
- R6: Each time `ras_n` rises, it stays high for at least RP_CYC cycles before it falls again.
- R7: A write drives `we_n` low and `dq_oe` high at least one cycle before `cas_n` falls. `dq_o` carries the write data while `cas_n` is low. `oe_n` is high whenever `dq_oe` is high.
- R8: A read holds `we_n` high and `oe_n` low. `dq_i` is sampled at the clock edge that ends the last `cas_n`-low cycle. The sampled value appears on `rd_data` with a one-cycle `rd_valid` pulse in the cycle in which `cas_n` has just risen.
- R9: `ras_n` is never low for more than RAS_MAX_CYC consecutive cycles. An open page that is idle or busy is closed early enough to meet this limit.
- R10: While `refresh_req` is high, `req_ready` is low and an open page is closed. `refresh_ok` is high whenever the page is closed, the precharge time has elapsed and no request is pending.
- R11: After reset `ras_n`, `cas_n`, `we_n` and `oe_n` are high, `dq_oe` and `rd_valid` are low, and `req_ready` and `refresh_ok` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Host address, row in the upper bits |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Request taken at this edge when `req_valid` is high |
| rd_valid | output | 1 | Read data pulse |
| rd_data | output | DW | Read data |
| refresh_req | input | 1 | Refresh engine wants the DRAM |
| refresh_ok | output | 1 | Page closed and precharged |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dq_o | output | DW | Data toward the pins |
| dq_oe | output | 1 | Drive enable for the tri-state data pad |
| dq_i | input | DW | Data from the pins |

## Verification
The bench contains a behavioural DRAM that presents read data only from the CAS_CYC-th cycle of `cas_n` low. A controller that captured data one cycle early would therefore return stale zeros. The bench counts row openings to separate page hits from misses: a controller that closed the page on every access, or never reopened the row on a miss, would show the wrong count or write to the wrong row. A long run of same-row requests and an idle open page drive `ras_n` toward its low-time limit, where a missing guard leaves the row strobe low too long. A refresh request raised while a page is open must first remove `req_ready` and then raise `refresh_ok` only after the full precharge.

// File: rtl/fpm_page_ctrl.sv
`timescale 1ns/1ps
module fpm_page_ctrl #(
  parameter int ROW_W       = 11,
  parameter int COL_W       = 11,
  parameter int DW          = 4,
  parameter int RAH_CYC     = 2,
  parameter int CAS_CYC     = 4,
  parameter int CP_CYC      = 2,
  parameter int RP_CYC      = 8,
  parameter int RAS_MAX_CYC = 24000
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  input  logic                                  req_write,
  input  logic [ROW_W+COL_W-1:0]                req_addr,
  input  logic [DW-1:0]                         req_wdata,
  output logic                                  req_ready,
  output logic                                  rd_valid,
  output logic [DW-1:0]                         rd_data,
  input  logic                                  refresh_req,
  output logic                                  refresh_ok,
  output logic                                  ras_n,
  output logic                                  cas_n,
  output logic                                  we_n,
  output logic                                  oe_n,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dram_addr,
  output logic [DW-1:0]                         dq_o,
  output logic                                  dq_oe,
  input  logic [DW-1:0]                         dq_i
);
  localparam int AW       = ROW_W + COL_W;
  localparam int MA_W     = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int CNT_W    = 8;
  localparam int AGE_W    = $clog2(RAS_MAX_CYC + 1);
  localparam int GUARD    = CAS_CYC + CP_CYC + 2;
  localparam int CLOSE_AT = RAS_MAX_CYC - GUARD;

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_COL, S_CAS, S_CP, S_OPEN} st_t;

  st_t              st_q, st_n;
  logic [CNT_W-1:0] cnt_q;
  logic [AGE_W-1:0] age_q;
  logic [AW-1:0]    a_q, a_n;
  logic             w_q, w_n, pend_q;
  logic [DW-1:0]    d_q, d_n;
  logic             rp_done, near_max, hit, acc, acc_ph;

  assign rp_done    = cnt_q >= CNT_W'(RP_CYC - 1);
  assign near_max   = age_q > AGE_W'(CLOSE_AT);
  assign hit        = req_addr[AW-1:COL_W] == a_q[AW-1:COL_W];
  assign refresh_ok = (st_q == S_IDLE) && rp_done && !pend_q;
  assign req_ready  = !refresh_req && ((st_q == S_IDLE && rp_done && !pend_q) ||
                                       (st_q == S_OPEN && !near_max));
  assign acc        = req_valid && req_ready;
  assign a_n        = acc ? req_addr  : a_q;
  assign w_n        = acc ? req_write : w_q;
  assign d_n        = acc ? req_wdata : d_q;
  assign acc_ph     = (st_n == S_COL) || (st_n == S_CAS);

  always_comb begin
    st_n = st_q;
    case (st_q)
      S_IDLE: if (rp_done && (pend_q || acc)) st_n = S_ROW;
      S_ROW:  if (cnt_q == CNT_W'(RAH_CYC - 1)) st_n = S_COL;
      S_COL:  st_n = S_CAS;
      S_CAS:  if (cnt_q == CNT_W'(CAS_CYC - 1)) st_n = S_CP;
      S_CP:   if (cnt_q == CNT_W'(CP_CYC - 1)) st_n = S_OPEN;
      S_OPEN: if (acc) st_n = hit ? S_COL : S_IDLE;
              else if (refresh_req || near_max) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      cnt_q     <= CNT_W'(RP_CYC - 1);
      age_q     <= '0;
      a_q       <= '0;
      w_q       <= 1'b0;
      d_q       <= '0;
      pend_q    <= 1'b0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      dq_oe     <= 1'b0;
      dq_o      <= '0;
      dram_addr <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      st_q  <= st_n;
      a_q   <= a_n;
      w_q   <= w_n;
      d_q   <= d_n;
      cnt_q <= (st_n != st_q) ? '0 : (st_q == S_IDLE && rp_done) ? cnt_q : cnt_q + 1'b1;
      age_q <= (st_n == S_IDLE) ? '0 : (st_q == S_IDLE) ? AGE_W'(1) : age_q + 1'b1;
      if (st_q == S_OPEN && acc && !hit) pend_q <= 1'b1;
      else if (st_q == S_IDLE && st_n == S_ROW) pend_q <= 1'b0;
      ras_n     <= st_n == S_IDLE;
      cas_n     <= st_n != S_CAS;
      we_n      <= !(acc_ph && w_n);
      dq_oe     <= acc_ph && w_n;
      oe_n      <= !(acc_ph && !w_n);
      dq_o      <= d_n;
      dram_addr <= (st_n == S_ROW) ? MA_W'(a_n[AW-1:COL_W]) : MA_W'(a_n[COL_W-1:0]);
      rd_valid  <= (st_q == S_CAS) && (cnt_q == CNT_W'(CAS_CYC - 1)) && !w_q;
      if ((st_q == S_CAS) && (cnt_q == CNT_W'(CAS_CYC - 1)) && !w_q) rd_data <= dq_i;
    end
  end
endmodule

// File: rtl/fpm_page_ctrl_chk.sv
`timescale 1ns/1ps
module fpm_page_ctrl_chk #(
  parameter int RP_CYC      = 8,
  parameter int RAS_MAX_CYC = 24000,
  parameter int MA_W        = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic            oe_n,
  input logic            dq_oe,
  input logic [MA_W-1:0] dram_addr,
  input logic            refresh_req,
  input logic            req_ready,
  input logic            rd_valid
);
  int lo_cnt, hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt <= 0;
      hi_cnt <= RP_CYC;
    end else begin
      lo_cnt <= ras_n ? 0 : lo_cnt + 1;
      hi_cnt <= !ras_n ? 0 : (hi_cnt < RP_CYC) ? hi_cnt + 1 : hi_cnt;
    end
  end

  p_ras_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> lo_cnt < RAS_MAX_CYC);
  p_precharge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> hi_cnt >= RP_CYC);
  p_cas_in_row_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  p_col_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n && $past(!cas_n)) |-> $stable(dram_addr));
  p_early_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !we_n) |-> ($past(!we_n) && $past(dq_oe)));
  p_no_contend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (oe_n && !we_n));
  p_rd_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(cas_n));
  p_refresh_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_req |-> !req_ready);
endmodule

bind fpm_page_ctrl fpm_page_ctrl_chk #(
  .RP_CYC(RP_CYC), .RAS_MAX_CYC(RAS_MAX_CYC), .MA_W(MA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .oe_n(oe_n), .dq_oe(dq_oe), .dram_addr(dram_addr), .refresh_req(refresh_req),
  .req_ready(req_ready), .rd_valid(rd_valid)
);

// File: tb/tb_fpm_page_ctrl.sv
`timescale 1ns/1ps
module tb_fpm_page_ctrl;
  localparam int ROW_W = 11, COL_W = 11, DW = 4, AW = ROW_W + COL_W;
  localparam int RAH = 2, CASC = 4, CP = 2, RP = 8, RMAX = 80;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, refresh_req = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, rd_data, dq_o, dq_i;
  logic req_ready, rd_valid, refresh_ok, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [10:0] dram_addr;

  fpm_page_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DW(DW), .RAH_CYC(RAH), .CAS_CYC(CASC),
                  .CP_CYC(CP), .RP_CYC(RP), .RAS_MAX_CYC(RMAX)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .refresh_req(refresh_req),
    .refresh_ok(refresh_ok), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .dram_addr(dram_addr), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i));

  always #2.5 clk = ~clk;

  typedef struct { bit w; int row; int col; logic [DW-1:0] d; } acc_t;
  acc_t acc_q[$];
  logic [DW-1:0] rdq[$];
  logic [DW-1:0] dmem[int];
  logic [DW-1:0] emem[int];
  int nchk = 0, nfail = 0, opens = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural DRAM and protocol reference, evaluated every cycle
  logic p_ras = 1, p_cas = 1, p_we = 1, p_oe = 0;
  logic [10:0] p_addr = '0, cas_addr = '0;
  int hi_run = 1000, lo_run = 0, since_fall = 0, cas_lo = 0, cas_hi = 0;
  int cur_row = 0, cur_col = 0;
  bit first_in_page = 0, moved = 0, col_bad = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_ras = 1; p_cas = 1; p_we = 1; p_oe = 0; hi_run = 1000; lo_run = 0;
      cas_lo = 0; cas_hi = 0; dq_i = '0;
    end else begin
      if (p_ras && !ras_n) begin
        chk(hi_run >= RP, "R6 precharge", hi_run, RP);
        chk(acc_q.size() > 0, "R1 unexpected row open", acc_q.size(), 1);
        if (acc_q.size() > 0) chk(int'(dram_addr) == acc_q[0].row, "R1 row", dram_addr, acc_q[0].row);
        cur_row = dram_addr; opens++; since_fall = 0; moved = 0; first_in_page = 1;
      end else if (!ras_n && !moved && dram_addr != p_addr) begin
        moved = 1;
        chk(since_fall >= RAH, "R2 row hold", since_fall, RAH);
      end
      if (p_cas && !cas_n) begin
        chk(!ras_n, "R3 cas without ras", ras_n, 0);
        chk(since_fall >= RAH + 1, "R2 ras to cas", since_fall, RAH + 1);
        if (!first_in_page) chk(cas_hi >= CP, "R3 cas precharge", cas_hi, CP);
        first_in_page = 0; cur_col = dram_addr; cas_addr = dram_addr; col_bad = 0;
        if (acc_q.size() == 0) chk(0, "R1 unexpected column strobe", 0, 1);
        else begin
          chk(cur_col == acc_q[0].col, "R1 column", cur_col, acc_q[0].col);
          chk(cur_row == acc_q[0].row, "R4/R5 row of access", cur_row, acc_q[0].row);
          chk(we_n == !acc_q[0].w, "R7/R8 direction", we_n, !acc_q[0].w);
          if (acc_q[0].w) begin
            chk(!p_we && p_oe, "R7 early write setup", {p_we, p_oe}, 2'b01);
            chk(dq_oe && oe_n && dq_o == acc_q[0].d, "R7 write data", dq_o, acc_q[0].d);
            dmem[cur_row * 4096 + cur_col] = dq_o;
          end else chk(!oe_n && !dq_oe, "R8 read enables", {oe_n, dq_oe}, 0);
          void'(acc_q.pop_front());
        end
      end else if (!cas_n && dram_addr != cas_addr) col_bad = 1;
      if (!p_cas && cas_n) begin
        chk(cas_lo == CASC && !col_bad, "R3 cas low width/addr", cas_lo, CASC);
      end
      if (!p_ras && ras_n) chk(lo_run <= RMAX, "R9 ras low time", lo_run, RMAX);
      if (rd_valid) begin
        if (rdq.size() == 0) chk(0, "R8 spurious rd_valid", 1, 0);
        else begin
          chk(rd_data == rdq[0], "R8 read data", rd_data, rdq[0]);
          void'(rdq.pop_front());
        end
      end
      if (ras_n) begin hi_run++; lo_run = 0; end else begin lo_run++; hi_run = 0; since_fall++; end
      if (cas_n) begin cas_hi++; cas_lo = 0; end else begin cas_lo++; cas_hi = 0; end
      if (!cas_n && we_n && !oe_n && cas_lo >= CASC)
        dq_i = dmem.exists(cur_row * 4096 + cur_col) ? dmem[cur_row * 4096 + cur_col] : '0;
      else dq_i = '0;
      p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_oe = dq_oe; p_addr = dram_addr;
    end
  end

  task automatic host(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    acc_t e;
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    e.w = w; e.row = int'(a[AW-1:COL_W]); e.col = int'(a[COL_W-1:0]); e.d = d;
    acc_q.push_back(e);
    if (w) emem[int'(a)] = d;
    else rdq.push_back(emem.exists(int'(a)) ? emem[int'(a)] : '0);
    #1 req_valid = 0;
  endtask

  function automatic logic [AW-1:0] mk(input int row, input int col);
    return {ROW_W'(row), COL_W'(col)};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int o0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk({ras_n, cas_n, we_n, oe_n} == 4'hF, "R11 strobes idle", {ras_n, cas_n, we_n, oe_n}, 4'hF);
    chk(!dq_oe && !rd_valid, "R11 no drive no data", {dq_oe, rd_valid}, 0);
    chk(req_ready && refresh_ok, "R11 ready and refresh_ok", {req_ready, refresh_ok}, 2'b11);

    // R4 page hits on a fresh row
    o0 = opens;
    host(1, mk(5, 1), 4'h3);
    host(1, mk(5, 2), 4'hC);
    host(0, mk(5, 1), 0);
    host(0, mk(5, 2), 0);
    repeat (12) @(negedge clk);
    chk(opens == o0 + 1, "R4 one row opening for same-row burst", opens - o0, 1);

    // R5 page misses
    o0 = opens;
    host(1, mk(7, 9), 4'h6);
    host(1, mk(9, 9), 4'h9);
    host(0, mk(7, 9), 0);
    repeat (12) @(negedge clk);
    chk(opens == o0 + 3, "R5 row reopened on each miss", opens - o0, 3);

    // R1 boundary address patterns
    host(1, mk(2047, 2047), 4'hF);
    host(1, mk(0, 0), 4'h1);
    host(1, mk(1365, 682), 4'hA);
    host(1, mk(682, 1365), 4'h5);
    host(0, mk(2047, 2047), 0);
    host(0, mk(0, 0), 0);
    host(0, mk(1365, 682), 0);
    host(0, mk(682, 1365), 0);

    // R9 long same-row run forces an early close
    o0 = opens;
    for (int i = 0; i < 12; i++) host(1, mk(3, i), DW'(i + 2));
    for (int i = 0; i < 12; i++) host(0, mk(3, i), 0);
    repeat (12) @(negedge clk);
    chk(opens - o0 >= 3, "R9 page closed before limit", opens - o0, 3);

    // R9 idle open page is closed on its own
    host(1, mk(11, 4), 4'h7);
    repeat (RMAX + 20) @(negedge clk);
    chk(ras_n == 1, "R9 idle page closed", ras_n, 1);

    // R10 refresh request while a page is open
    host(1, mk(12, 8), 4'hB);
    repeat (10) @(negedge clk);
    chk(ras_n == 0, "R10 page open before refresh", ras_n, 0);
    refresh_req = 1;
    #0.1;
    chk(req_ready == 0, "R10 ready dropped", req_ready, 0);
    @(negedge clk);
    chk(refresh_ok == 0, "R10 refresh_ok waits for precharge", refresh_ok, 0);
    repeat (RP + 2) @(negedge clk);
    chk(ras_n == 1 && refresh_ok == 1, "R10 closed and precharged", {ras_n, refresh_ok}, 2'b11);
    refresh_req = 0;
    host(0, mk(12, 8), 0);
    host(0, mk(11, 4), 0);

    repeat (30) @(negedge clk);
    chk(acc_q.size() == 0 && rdq.size() == 0, "R8 all accesses completed",
        acc_q.size() + rdq.size(), 0);
    finish_run();
  end
endmodule